// File: doc/BRIEF.md
# Three-Pattern Streaming Regex Matcher

This block watches a byte stream, one byte per clock when `in_valid` is high. It looks for three fixed patterns at the same time: `abcd`, `r`, and `s(ef)+g`. In the last pattern, the pair `ef` appears one or more times between `s` and `g`. The search is unanchored, so any byte may begin a new attempt, and matches may overlap. Each pattern has a match output that pulses for one cycle, in the cycle after the byte that completes it.

The design is a nondeterministic automaton built in hardware. A single character decoder drives one hit line per character of interest, and every state uses those lines. Each state register holds the AND of its predecessor states with the hit line for its own character. The loop in `s(ef)+g` is an OR of `s` and `f` into the input of the `e` state. There are ten states: a start node, then a, b, c, d, r, s, e, f and g.

The parameter `PACK_EFG` picks how the states are stored:
- At 0, every state has its own flip-flop.
- At 1, the e, f and g states share two flip-flops. The codes are e=01, f=10, g=11, and 00 means none of the three is active. This works because each of those states needs a different current byte, so no two of them can be active together.

The two builds produce the same match pulses.

Top module: `regex_nfa_matcher`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all three match outputs are 0 and every state is cleared.
- R2: `match_abcd` is 1 in exactly the cycle after a valid `d` is accepted whose three previous valid bytes were `a`, `b`, `c`. This includes overlapping input such as `abcabcd`.
- R3: `match_r` is 1 in the cycle after every valid `r` byte, including back-to-back `r` bytes.
- R4: `match_seg` is 1 in the cycle after a valid `g` whose previous valid bytes form `s` followed by one or more `ef` pairs (for example `sefg` and `sefefg`).
- R5: `match_seg` stays 0 when the `ef` loop is absent or broken (for example `sg`, `seg`, `seffg`).
- R6: A cycle with `in_valid` low does not change any state and gives no match pulse in the next cycle. The byte seen in that cycle is ignored, so a pattern split by idle cycles still matches.
- R7: Matching is unanchored: a new attempt starts at every valid byte (for example `aabcd` and `ssefg` match).
- R8: Each match pulse lasts exactly one cycle per completing byte, even when idle cycles follow.
- R9: With `PACK_EFG`=1, the e/f/g group is stored in two flip-flops using codes e=01, f=10, g=11 and none=00. The match outputs are identical to the `PACK_EFG`=0 build for every input stream.
- R10: At most one of the nine character states is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Byte strobe; when low the byte is ignored and state holds |
| in_byte | input | 8 | Input character |
| match_abcd | output | 1 | One-cycle pulse on a completed `abcd` |
| match_r | output | 1 | One-cycle pulse on an `r` |
| match_seg | output | 1 | One-cycle pulse on a completed `s(ef)+g` |

## Verification
The assertions assume the following about the inputs:
- `in_valid` and `in_byte` are stable around the rising edge and never X once reset is released. The pulse checks compare against `$past` of those inputs.
- The exclusivity checks assume only that one byte arrives per cycle. This is what makes packing e, f and g legal.

The stimulus drives inputs only on falling edges. It keeps two idle cycles after reset so the always-active start node is set before the first byte. It covers the following input sets:
- every five-letter word over {s,e,f,g};
- every five-letter word over {a,b,c,d};
- a pseudo-random stream over all pattern letters plus a filler, with idle cycles mixed in.

// File: rtl/regex_nfa_pkg.sv
package regex_nfa_pkg;

  // State indices: start node, then one state per pattern character
  localparam int ST_START = 0;
  localparam int ST_A     = 1;
  localparam int ST_B     = 2;
  localparam int ST_C     = 3;
  localparam int ST_D     = 4;
  localparam int ST_R     = 5;
  localparam int ST_S     = 6;
  localparam int ST_E     = 7;
  localparam int ST_F     = 8;
  localparam int ST_G     = 9;
  localparam int NUM_ST   = 10;

  // Character hit-line indices
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_C   = 2;
  localparam int CH_D   = 3;
  localparam int CH_R   = 4;
  localparam int CH_S   = 5;
  localparam int CH_E   = 6;
  localparam int CH_F   = 7;
  localparam int CH_G   = 8;
  localparam int NUM_CH = 9;

  localparam int BYTE_W = 8;

  typedef logic [NUM_ST-1:0] st_vec_t;
  typedef logic [NUM_CH-1:0] hit_vec_t;

  // Two-flip-flop codes for the packed e/f/g group
  typedef enum logic [1:0] {
    GRP_NONE = 2'b00,
    GRP_E    = 2'b01,
    GRP_F    = 2'b10,
    GRP_G    = 2'b11
  } grp_code_e;

  function automatic logic [BYTE_W-1:0] char_of(input int idx);
    logic [BYTE_W-1:0] ch;
    case (idx)
      CH_A:    ch = "a";
      CH_B:    ch = "b";
      CH_C:    ch = "c";
      CH_D:    ch = "d";
      CH_R:    ch = "r";
      CH_S:    ch = "s";
      CH_E:    ch = "e";
      CH_F:    ch = "f";
      default: ch = "g";
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/nfa_char_decoder.sv
module nfa_char_decoder
  import regex_nfa_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] in_byte,
  output hit_vec_t     hits
);

  // One comparator per character of interest, shared by every state
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cmp
    localparam logic [W-1:0] CODE = W'(char_of(gi));
    assign hits[gi] = (in_byte == CODE);
  end

  // R10: distinct characters give mutually exclusive hit lines
  always_comb begin
    a_hits_excl_r10: assert ($onehot0(hits));
  end

endmodule

// File: rtl/nfa_step.sv
module nfa_step
  import regex_nfa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  st_vec_t  cur,
  input  hit_vec_t hits,
  output st_vec_t  nxt
);

  st_vec_t step;

  // Transition logic: each state = predecessors AND own hit line
  always_comb begin
    step           = '0;
    step[ST_START] = 1'b1;
    // abcd chain
    step[ST_A] = cur[ST_START] & hits[CH_A];
    step[ST_B] = cur[ST_A]     & hits[CH_B];
    step[ST_C] = cur[ST_B]     & hits[CH_C];
    step[ST_D] = cur[ST_C]     & hits[CH_D];
    // single r
    step[ST_R] = cur[ST_START] & hits[CH_R];
    // s(ef)+g with feedback from f into e's input
    step[ST_S] = cur[ST_START] & hits[CH_S];
    step[ST_E] = (cur[ST_S] | cur[ST_F]) & hits[CH_E];
    step[ST_F] = cur[ST_E]     & hits[CH_F];
    step[ST_G] = cur[ST_F]     & hits[CH_G];
  end

  // Clock enable written out: hold when no byte is offered
  always_comb begin
    if (in_valid) begin
      nxt = step;
    end else begin
      nxt = cur;
      nxt[ST_START] = 1'b1;
    end
  end

  // R10: the next state vector keeps at most one character state
  p_next_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nxt[NUM_ST-1:1]));

  // R6: a held cycle carries the character states over unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (nxt[NUM_ST-1:1] == cur[NUM_ST-1:1]));

endmodule

// File: rtl/nfa_state_store.sv
module nfa_state_store
  import regex_nfa_pkg::*;
#(
  parameter bit PACK_EFG = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t nxt,
  output st_vec_t cur
);

  localparam int PLAIN_N = PACK_EFG ? (NUM_ST - 3) : NUM_ST;

  if (!PACK_EFG) begin : g_onehot
    st_vec_t st_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= nxt;
    end

    assign cur = st_q;

    // R10: one flip-flop per state, never two character states at once
    p_store_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_q[NUM_ST-1:1]));

  end else begin : g_packed
    logic [PLAIN_N-1:0] plain_q;
    grp_code_e          grp_q;
    grp_code_e          grp_d;

    // Encode the e/f/g group into two flip-flops
    always_comb begin
      unique case (1'b1)
        nxt[ST_E]: grp_d = GRP_E;
        nxt[ST_F]: grp_d = GRP_F;
        nxt[ST_G]: grp_d = GRP_G;
        default:   grp_d = GRP_NONE;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plain_q <= '0;
        grp_q   <= GRP_NONE;
      end else begin
        plain_q <= nxt[PLAIN_N-1:0];
        grp_q   <= grp_d;
      end
    end

    // Decode back to the logical state vector
    always_comb begin
      cur                = '0;
      cur[PLAIN_N-1:0]   = plain_q;
      cur[ST_E]          = (grp_q == GRP_E);
      cur[ST_F]          = (grp_q == GRP_F);
      cur[ST_G]          = (grp_q == GRP_G);
    end

    // R9: packing legal only if group members are never co-active
    p_group_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nxt[ST_E], nxt[ST_F], nxt[ST_G]}));

    // R9: a stored g code must come from an f followed by a g request
    p_group_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_d == GRP_G) |-> nxt[ST_G]);
  end

endmodule

// File: rtl/regex_nfa_matcher.sv
module regex_nfa_matcher
  import regex_nfa_pkg::*;
#(
  parameter bit PACK_EFG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              match_abcd,
  output logic              match_r,
  output logic              match_seg
);

  hit_vec_t hits;
  st_vec_t  cur;
  st_vec_t  nxt;
  logic     stepped_q;

  nfa_char_decoder #(.W(BYTE_W)) u_dec (
    .in_byte (in_byte),
    .hits    (hits)
  );

  nfa_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cur      (cur),
    .hits     (hits),
    .nxt      (nxt)
  );

  nfa_state_store #(.PACK_EFG(PACK_EFG)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .cur   (cur)
  );

  // Marks cycles whose state was just produced by an accepted byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stepped_q <= 1'b0;
    else        stepped_q <= in_valid;
  end

  assign match_abcd = cur[ST_D] & stepped_q;
  assign match_r    = cur[ST_R] & stepped_q;
  assign match_seg  = cur[ST_G] & stepped_q;

  // R6/R8: an idle cycle is followed by no pulse
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(match_abcd | match_r | match_seg));

  // R3: every accepted r pulses match_r next cycle, given start active
  p_r_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte == "r" && cur[ST_START]) |=> match_r);

  // R2: an abcd pulse follows an accepted d
  p_abcd_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_abcd |-> ($past(in_valid) && $past(in_byte) == "d"));

  // R4: an s(ef)+g pulse follows an accepted g
  p_seg_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_seg |-> ($past(in_valid) && $past(in_byte) == "g"));

  // R10: at most one pattern completes per byte
  p_one_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match_abcd, match_r, match_seg}));

endmodule

// File: tb/regex_nfa_matcher_tb.sv
module regex_nfa_matcher_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       m_abcd, m_r, m_seg;
  logic       p_abcd, p_r, p_seg;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  logic [7:0] hist [0:15];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  regex_nfa_matcher #(.PACK_EFG(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .match_abcd(m_abcd), .match_r(m_r), .match_seg(m_seg));

  regex_nfa_matcher #(.PACK_EFG(1'b1)) u_dut_pk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .match_abcd(p_abcd), .match_r(p_r), .match_seg(p_seg));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: act=%b exp=%b (abcd,r,seg) at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [2:0] model();
    logic [2:0] e;
    int k;
    int pairs;
    e[2] = (hist[3] == "a") && (hist[2] == "b") && (hist[1] == "c") && (hist[0] == "d");
    e[1] = (hist[0] == "r");
    k = 1;
    pairs = 0;
    while (k < 14 && hist[k] == "f" && hist[k+1] == "e") begin
      k += 2;
      pairs++;
    end
    e[0] = (hist[0] == "g") && (pairs > 0) && (hist[k] == "s");
    return e;
  endfunction

  // Drive one cycle; sample results at the next falling edge
  task automatic push(input logic v, input logic [7:0] b, input string req);
    logic [2:0] exp;
    in_valid = v;
    in_byte  = b;
    if (v) begin
      for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b;
      exp = model();
    end else begin
      exp = 3'b000;
    end
    @(negedge clk);
    chk(req, {m_abcd, m_r, m_seg}, exp);
    chk("R9", {p_abcd, p_r, p_seg}, {m_abcd, m_r, m_seg});
  endtask

  task automatic send_str(input string s, input string req);
    for (int i = 0; i < s.len(); i++) push(1'b1, s[i], req);
  endtask

  function automatic logic [7:0] pick(input logic [15:0] r);
    logic [7:0] alpha [0:9];
    alpha = '{"a", "b", "c", "d", "r", "s", "e", "f", "g", "x"};
    return alpha[r % 10];
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) hist[i] = "x";
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_byte = "r";
    @(negedge clk);
    chk("R1", {m_abcd, m_r, m_seg}, 3'b000);
    @(negedge clk);
    chk("R1", {p_abcd, p_r, p_seg}, 3'b000);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", {m_abcd, m_r, m_seg}, 3'b000);
    @(negedge clk);

    send_str("xabcdx", "R2");
    send_str("abcabcd", "R2");
    send_str("rrxr", "R3");
    send_str("sefgxsefefgx", "R4");
    send_str("sgxsegxseffgxsefeg", "R5");
    send_str("aabcdssefgx", "R7");
    // R6: idle cycles with pattern bytes on the bus are ignored
    send_str("ab", "R6");
    push(1'b0, "r", "R6");
    push(1'b0, "d", "R6");
    send_str("cd", "R6");
    // R8: pulse does not linger through idle cycles
    send_str("r", "R8");
    push(1'b0, "x", "R8");
    push(1'b0, "x", "R8");

    // Exhaustive five-letter words over {s,e,f,g}, then {a,b,c,d}
    for (int w = 0; w < 1024; w++) begin
      logic [7:0] sefg [0:3];
      sefg = '{"s", "e", "f", "g"};
      for (int p = 0; p < 5; p++) push(1'b1, sefg[(w >> (2*p)) & 3], "R4");
    end
    for (int w = 0; w < 1024; w++) begin
      for (int p = 0; p < 5; p++) push(1'b1, 8'("a" + ((w >> (2*p)) & 3)), "R2");
    end

    // Pseudo-random stream with idle cycles
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(lfsr[2:0] != 3'd0, pick(lfsr >> 3), "R6");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule